// File: doc/BRIEF.md
# SDRAM burst column sequencer

This block produces the column address sequence for a single read or write burst inside a synchronous DRAM device or its model. A mode word is held in a register. It selects the burst length, the wrap order, and whether writes are limited to one access while reads keep the programmed length. A start strobe carries a start column and a read/write flag. The block then issues one column per clock and marks the final access with a done pulse.

A burst ends in one of three ways. It can run its full length. It can be cut short by a terminate strobe, which stands for either a burst-stop or a precharge command. It can be replaced by a new start strobe. A full-page burst walks the whole page and wraps around until it is terminated or replaced. The memory array, the CAS latency delay, data masking and refresh all live outside this block.

Top module: `sdram_burst_colseq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no start, `col_valid` and `burst_done` are low.
- R2: A start sampled at clock edge t puts access 0 on `col` at `start_col` with `col_valid` high in the cycle after edge t. Each further edge issues the next access, one column per cycle.
- R3: Bits [2:0] of the mode word set the length. 000 means 1 access, 001 means 2, 010 means 4, 011 means 8 and 111 means full page. `burst_done` is high together with the last access of a finite burst, and `col_valid` is low in the following cycle unless a new start was sampled.
- R4: Mode bit 3 = 0 selects sequential order. The low log2(length) column bits count upward modulo the length, starting from those bits of `start_col`. The upper bits stay those of `start_col`.
- R5: Mode bit 3 = 1 selects interleaved order. Access i uses the low log2(length) bits of `start_col` XORed with i. The upper bits are unchanged.
- R6: A full-page burst issues start_col + i modulo 2^COL_W and continues without limit. `burst_done` is never raised for it.
- R7: A terminate strobe sampled during a burst, with no start in the same cycle, drops `col_valid` in the next cycle and gives no `burst_done`.
- R8: Mode bit 4 = 1 makes every write burst a single access with `burst_done`. Reads keep the programmed length.
- R9: A start sampled during a burst abandons that burst without `burst_done`. The new burst's access 0 appears in the next cycle. A start takes priority over a terminate strobe in the same cycle.
- R10: `mode_load` updates the mode register only in a cycle where no burst is active. A start uses the mode held before its own cycle's load.
- R11: Length codes 100, 101 and 110 act as length 1. A full-page burst ignores mode bit 3 and always counts sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_load | input | 1 | Load `mode_word` into the mode register when idle |
| mode_word | input | 5 | {single-write, interleave, length code[2:0]} |
| start | input | 1 | Begin a burst |
| start_wr | input | 1 | 1 for a write burst, 0 for a read burst |
| start_col | input | COL_W | First column of the burst |
| term | input | 1 | Terminate the current burst |
| col | output | COL_W | Column of the current access |
| col_valid | output | 1 | `col` carries an access this cycle |
| burst_done | output | 1 | This access is the last of a finite burst |

## Verification
A corrupted index or base register shows up as a wrong `col` in the very next issued access. A corrupted length mask shows up differently: either `burst_done` comes too early, or `col_valid` stays high beyond the final access, at the latest by the eighth access. A mode register that changes during a burst is invisible until the next start. For that reason the bench loads a different mode mid-burst and then starts a fresh burst, so the ignored load shows up in the length and order of that burst. Terminate and restart are issued at arbitrary offsets. This makes a stuck active flag show up as an extra valid cycle one clock later.

// File: rtl/sdram_colseq_pkg.sv
package sdram_colseq_pkg;

    localparam int MODE_W = 5;

    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;

    typedef struct packed {
        logic       single_wr;
        logic       interleave;
        logic [2:0] len_code;
    } mode_t;

endpackage

// File: rtl/colseq_len_decode.sv
module colseq_len_decode
    import sdram_colseq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  mode_t            mode,
    input  logic             is_write,
    output logic [COL_W-1:0] span_mask,
    output logic             full_page
);
    logic [3:0] span_log2;
    logic       force_single;

    always_comb begin
        force_single = is_write && mode.single_wr;
        full_page    = 1'b0;
        span_log2    = 4'd0;
        if (!force_single) begin
            case (mode.len_code)
                LEN_TWO:   span_log2 = 4'd1;
                LEN_FOUR:  span_log2 = 4'd2;
                LEN_EIGHT: span_log2 = 4'd3;
                LEN_PAGE:  full_page = 1'b1;
                default:   span_log2 = 4'd0;  // R11: reserved codes are length 1
            endcase
        end
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_mask_bit
        assign span_mask[b] = full_page || ({28'd0, span_log2} > 32'(b));
    end

endmodule

// File: rtl/colseq_addr_gen.sv
module colseq_addr_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] step_idx,
    input  logic [COL_W-1:0] span_mask,
    input  logic             interleave,
    input  logic             full_page,
    output logic [COL_W-1:0] col_addr
);
    logic [COL_W-1:0] fixed_bits;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    always_comb begin
        fixed_bits = base_col & ~span_mask;
        seq_low    = (base_col + step_idx) & span_mask;
        ilv_low    = (base_col ^ step_idx) & span_mask;
        // full page runs with an all-ones mask, so the sequential path is base + idx
        if (interleave && !full_page) col_addr = fixed_bits | ilv_low;
        else                          col_addr = fixed_bits | seq_low;
    end

endmodule

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq
    import sdram_colseq_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [4:0]       mode_word,
    input  logic             start,
    input  logic             start_wr,
    input  logic [COL_W-1:0] start_col,
    input  logic             term,
    output logic [COL_W-1:0] col,
    output logic             col_valid,
    output logic             burst_done
);
    localparam logic [COL_W-1:0] IDX_ONE = COL_W'(1);

    typedef struct packed {
        logic             active;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        mode_t            mode;
    } state_t;

    state_t s_d, s_q;

    logic [COL_W-1:0] new_mask;
    logic             new_full;
    logic             last_access;

    colseq_len_decode #(.COL_W(COL_W)) i_len_decode (
        .mode      (s_q.mode),
        .is_write  (start_wr),
        .span_mask (new_mask),
        .full_page (new_full)
    );

    colseq_addr_gen #(.COL_W(COL_W)) i_addr_gen (
        .base_col   (s_q.base),
        .step_idx   (s_q.idx),
        .span_mask  (s_q.mask),
        .interleave (s_q.ilv),
        .full_page  (s_q.full),
        .col_addr   (col)
    );

    assign last_access = s_q.active && !s_q.full && (s_q.idx == s_q.mask);

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.active = 1'b1;
            s_d.full   = new_full;
            s_d.ilv    = s_q.mode.interleave;
            s_d.mask   = new_mask;
            s_d.base   = start_col;
            s_d.idx    = '0;
        end else if (s_q.active) begin
            if (term || last_access) s_d.active = 1'b0;
            else                     s_d.idx    = s_q.idx + IDX_ONE;
        end
        if (mode_load && !s_q.active) s_d.mode = mode_t'(mode_word);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign col_valid  = s_q.active;
    assign burst_done = last_access;

    p_done_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> col_valid);
    p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done && !start |=> !col_valid);
    p_start_issues_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && (col == $past(start_col)));
    p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && !s_q.full |-> (((col ^ s_q.base) & ~s_q.mask) == '0));
    p_page_no_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && s_q.full |-> !burst_done);
    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && s_q.full && !term && !start |=> col == COL_W'($past(col) + IDX_ONE));
    p_term_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && term && !start |=> !col_valid);
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start && start_wr && s_q.mode.single_wr |=> burst_done);
    p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |=> $stable(s_q.mode));

endmodule

// File: tb/test_sdram_burst_colseq.sv
`timescale 1ns/1ps
module test_sdram_burst_colseq;
    localparam int COL_W = 9;
    localparam int PAGE  = 1 << COL_W;

    logic clk = 1'b0;
    logic rst_n;
    logic mode_load;
    logic [4:0] mode_word;
    logic start, start_wr, term;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] col;
    logic col_valid, burst_done;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    sdram_burst_colseq #(.COL_W(COL_W)) i_sdram_burst_colseq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_wr(start_wr), .start_col(start_col), .term(term),
        .col(col), .col_valid(col_valid), .burst_done(burst_done)
    );

    // behavioural reference
    int m_active, m_i, m_len, m_st;
    bit m_ilv, m_full;
    logic [4:0] m_mode;

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            3'b111:  return PAGE;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int st, input int i, input int len,
                                   input bit ilv, input bit full);
        int base, off;
        if (full) return (st + i) % PAGE;
        off  = st % len;
        base = st - off;
        if (ilv) return base + (off ^ i);
        return base + ((off + i) % len);
    endfunction

    always @(posedge clk) begin
        int old_active;
        logic [4:0] old_mode;
        old_active = m_active;
        old_mode   = m_mode;
        if (!rst_n) begin
            m_active = 0; m_i = 0; m_len = 1; m_st = 0;
            m_ilv = 0; m_full = 0; m_mode = '0;
        end else begin
            if (start) begin
                m_active = 1;
                m_i      = 0;
                m_st     = int'(start_col);
                m_ilv    = old_mode[3];
                m_len    = len_of(old_mode[2:0]);
                m_full   = (old_mode[2:0] == 3'b111);
                if (start_wr && old_mode[4]) begin
                    m_len  = 1;
                    m_full = 0;
                end
            end else if (m_active != 0) begin
                if (term) m_active = 0;
                else if (!m_full && m_i == m_len - 1) m_active = 0;
                else m_i = m_i + 1;
            end
            if (mode_load && old_active == 0) m_mode = mode_word;
        end
    end

    task automatic check();
        bit e_valid, e_done;
        int e_col;
        e_valid = (m_active != 0);
        e_done  = e_valid && !m_full && (m_i == m_len - 1);
        e_col   = exp_col(m_st, m_i, m_len, m_ilv, m_full);
        n_checks++;
        if (col_valid !== e_valid) begin
            n_fails++;
            $display("FAIL %s col_valid actual %b expected %b at %0t", cur_req, col_valid, e_valid, $time);
        end
        n_checks++;
        if (burst_done !== e_done) begin
            n_fails++;
            $display("FAIL %s burst_done actual %b expected %b at %0t", cur_req, burst_done, e_done, $time);
        end
        if (e_valid) begin
            n_checks++;
            if (int'(col) !== e_col) begin
                n_fails++;
                $display("FAIL %s col actual %0d expected %0d at %0t", cur_req, col, e_col, $time);
            end
        end
    endtask

    task automatic cyc(input bit s, input bit w, input int c, input bit t,
                       input bit ld, input logic [4:0] mw);
        start = s; start_wr = w; start_col = COL_W'(c); term = t;
        mode_load = ld; mode_word = mw;
        @(negedge clk);
        check();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 5'b0);
    endtask

    task automatic load(input logic [4:0] mw);
        cyc(0, 0, 0, 0, 1, mw);
    endtask

    task automatic burst(input bit w, input int c, input int n);
        cyc(1, w, c, 0, 0, 5'b0);
        idle(n);
    endtask

    initial begin
        rst_n = 0;
        start = 0; start_wr = 0; start_col = '0; term = 0; mode_load = 0; mode_word = '0;
        @(negedge clk);
        cur_req = "R1";
        idle(3);
        rst_n = 1;
        idle(2);

        cur_req = "R4"; load(5'b00010); burst(0, 13, 5);   // seq length 4
        cur_req = "R2"; burst(0, 200, 5);
        cur_req = "R5"; load(5'b01011); burst(0, 37, 9);   // interleaved length 8
        burst(1, 254, 9);
        cur_req = "R3"; load(5'b00000); burst(0, 77, 3);   // length 1
        load(5'b00001); burst(0, 99, 3);                   // length 2
        load(5'b00011); burst(0, 5, 10);                   // seq length 8
        cur_req = "R6"; load(5'b00111); burst(0, 508, 12); // full page wraps
        cur_req = "R7"; cyc(0, 0, 0, 1, 0, 5'b0); idle(2);
        cur_req = "R11"; load(5'b01111); burst(1, 3, 6);
        cyc(0, 0, 0, 1, 0, 5'b0); idle(2);
        load(5'b00101); burst(0, 66, 3);                   // reserved code
        load(5'b00110); burst(0, 67, 3);
        cur_req = "R7"; load(5'b00011); burst(0, 40, 3);
        cyc(0, 0, 0, 1, 0, 5'b0); idle(3);
        cur_req = "R8"; load(5'b10011); burst(1, 21, 3);
        burst(0, 21, 10);
        load(5'b00010); burst(1, 22, 6);                   // option off: write bursts
        cur_req = "R9"; load(5'b00011); cyc(1, 0, 10, 0, 0, 5'b0); idle(3);
        cyc(1, 0, 300, 1, 0, 5'b0); idle(2);
        cyc(1, 1, 450, 0, 0, 5'b0); idle(10);
        cur_req = "R10"; cyc(1, 0, 16, 0, 0, 5'b0); idle(1);
        load(5'b01001); idle(8);                           // ignored during burst
        burst(0, 51, 10);                                  // still seq length 8
        cyc(1, 0, 90, 0, 1, 5'b01001); idle(10);           // start uses old mode
        burst(0, 91, 4);                                   // now interleaved length 2
        cur_req = "R1"; rst_n = 0; idle(1); rst_n = 1; idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule